// File: doc/BRIEF.md
# Quadrature-Mixing Two-Word NCO

This block is the core of a direct digital synthesizer. A 32-bit phase accumulator advances once per clock by one of two frequency tuning words. A select input chooses the word on every cycle, so a serial bit stream on that input gives frequency-shift keying with no setup between symbols. The top twelve accumulator bits, plus a 12-bit phase offset, address a sine table and a cosine table. The cosine table is the sine table read a quarter turn ahead. Both tables are built from one quarter-wave table that is computed at elaboration.

With amplitude mixing off, the output is the cosine sample. With mixing on, the sine sample is scaled by the upper half of a 20-bit gain word and the cosine sample by the lower half. The two products are added and the sum is rescaled into one 10-bit code for an external converter. A pin or a control bit can put the block to sleep. While asleep, the accumulator and the sample pipeline are frozen and the output code is held at zero. The tuning words, phase offset, gain word and control bits come from register logic outside this block.

Top module: `nco_qam_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `dacCode` is 0. Reset clears the accumulator to 0 and clears both sample registers to code 0.
- R2: On each clock edge while awake, the accumulator adds `freqWord1` if `freqSel` is 1, or `freqWord0` if it is 0, sampled at that edge. The sum wraps modulo 2^32.
- R3: The table address is (accumulator bits [31:20] + `phaseOffset`) mod 4096. It is taken from the accumulator value before the edge on which the samples are registered.
- R4: The sine sample for address a is computed as follows. Let q = a[11:10] and k = a[9:0]. Let i = k when q[0]=0 and i = 1023-k when q[0]=1. Let m = round(511.5·sin(π(2i+1)/4096)). The sample is 512+m when q[1]=0 and 511-m when q[1]=1.
- R5: The cosine sample for address a equals the sine sample for address (a+1024) mod 4096. At accumulator 0 with zero offset, the cosine sample is 1023.
- R6: The control word has bit 0 for amplitude mixing and bit 1 for sleep. With bit 0 clear, `dacCode` after an edge equals the cosine sample registered on the previous edge.
- R7: With control bit 0 set, let s and c be the registered sine and cosine samples minus 512, gS = `iqWord[19:10]`-512 and gC = `iqWord[9:0]`-512. Then `dacCode` = floor((s·gS + c·gC)/1024) + 512. Gains of 512 on both halves give 512.
- R8: When `sleepPin` is high at an edge, the accumulator and both sample registers keep their values and `dacCode` becomes 0. When it goes low, operation continues from the held phase.
- R9: Control bit 1 has the same effect as `sleepPin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock |
| rst | input | 1 | Asynchronous reset, active high |
| sleepPin | input | 1 | Sleep request, active high |
| cmdWord | input | 2 | Bit 0 enables amplitude mixing, bit 1 requests sleep |
| freqWord0 | input | 32 | Tuning word used when `freqSel` is 0 |
| freqWord1 | input | 32 | Tuning word used when `freqSel` is 1 |
| freqSel | input | 1 | Per-cycle tuning word select |
| phaseOffset | input | 12 | Phase offset added to the table address |
| iqWord | input | 20 | Gains: [19:10] for the sine path, [9:0] for the cosine path, offset binary |
| dacCode | output | 10 | Offset-binary code for the converter |

## Verification
A bad accumulator step or a wrong word selection does not show up as a single wrong cycle. It appears as a phase error two edges later that then persists, so the output drifts away from the reference model and never recovers. A wrong table entry, quadrant fold or gain sign shows up in the output code at that same two-edge latency, but only on the addresses and gain patterns that exercise it. For that reason the bench compares every cycle across sweeps, keying patterns, offsets and gain pairs. A sleep fault is visible one edge after the request: the output is not zero, or after wake the output resumes from the wrong phase.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int CMD_W         = 2;
  localparam int CMD_AM_BIT    = 0;
  localparam int CMD_SLEEP_BIT = 1;

  typedef struct packed {
    logic advance;   // pipeline may update this cycle
    logic blank;     // force output code to zero
    logic amEnable;  // use the mixed I/Q sum
  } ctrl_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic             sleepPin,
  input  logic [CMD_W-1:0] cmdWord,
  output ctrl_t            ctrl
);
  logic halted;

  always_comb begin
    halted        = sleepPin | cmdWord[CMD_SLEEP_BIT];
    ctrl.advance  = ~halted;
    ctrl.blank    = halted;
    ctrl.amEnable = cmdWord[CMD_AM_BIT];
  end
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 10
) (
  input  logic [PHASE_W-1:0]  addr,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int    QUARTER = 1 << (PHASE_W - 2);
  localparam int    MAG_W   = SAMPLE_W - 1;
  localparam int    FRAC    = 30;
  localparam longint PI_FX  = 64'd3373259426;   // pi * 2^30
  localparam longint FULL   = longint'(1) <<< PHASE_W;

  typedef logic [MAG_W-1:0] quarter_t [QUARTER];

  // Quarter-wave magnitudes from a fixed-point Taylor series, sampled at
  // half-step offsets so that every quadrant is an exact mirror.
  function automatic quarter_t buildQuarter();
    quarter_t tab;
    longint x, term, sum;
    for (int k = 0; k < QUARTER; k++) begin
      x    = (longint'(2 * k + 1) * PI_FX) / FULL;
      term = x;
      sum  = x;
      for (int n = 1; n <= 7; n++) begin
        term = (term * x) >>> FRAC;
        term = (term * x) >>> FRAC;
        term = -term / longint'((2 * n) * (2 * n + 1));
        sum  = sum + term;
      end
      tab[k] = MAG_W'((sum * longint'((1 << SAMPLE_W) - 1) + (longint'(1) <<< FRAC)) >>> (FRAC + 1));
    end
    return tab;
  endfunction

  localparam quarter_t QTAB = buildQuarter();

  logic [1:0]         quad;
  logic [PHASE_W-3:0] slot;
  logic [PHASE_W-3:0] idx;
  logic [MAG_W-1:0]   mag;

  always_comb begin
    quad   = addr[PHASE_W-1 -: 2];
    slot   = addr[PHASE_W-3:0];
    idx    = quad[0] ? ~slot : slot;
    mag    = QTAB[idx];
    sample = quad[1] ? {1'b0, ~mag} : {1'b1, mag};
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrl_t                 ctrl,
  input  logic [ACC_W-1:0]      freqWord0,
  input  logic [ACC_W-1:0]      freqWord1,
  input  logic                  freqSel,
  input  logic [PHASE_W-1:0]    phaseOffset,
  input  logic [2*SAMPLE_W-1:0] iqWord,
  output logic [ACC_W-1:0]      accValue,
  output logic [SAMPLE_W-1:0]   cosSample,
  output logic [SAMPLE_W-1:0]   dacCode
);
  localparam int QUARTER_OFS = 1 << (PHASE_W - 2);
  localparam int SUM_W       = 2 * SAMPLE_W + 1;
  localparam int N_PATH      = 2;   // 0: sine, 1: cosine

  logic [ACC_W-1:0]    accQ;
  logic [PHASE_W-1:0]  baseAddr;
  logic [SAMPLE_W-1:0] lutOut  [N_PATH];
  logic [SAMPLE_W-1:0] sampleQ [N_PATH];
  logic [SAMPLE_W-1:0] dacQ;

  assign baseAddr = accQ[ACC_W-1 -: PHASE_W] + phaseOffset;

  for (genvar g = 0; g < N_PATH; g++) begin : gPath
    logic [PHASE_W-1:0] pathAddr;
    assign pathAddr = baseAddr + PHASE_W'(g * QUARTER_OFS);
    nco_sine_lut #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) lut_i (
      .addr   (pathAddr),
      .sample (lutOut[g])
    );
  end

  // Offset binary to two's complement: invert the MSB.
  logic signed [SAMPLE_W-1:0] sinS, cosS, gainSin, gainCos;
  logic signed [SUM_W-1:0]    mixSum;
  logic [SAMPLE_W-1:0]        mixTwos;
  logic [SAMPLE_W-1:0]        mixCode;
  logic [SAMPLE_W-1:0]        nextDac;

  always_comb begin
    sinS    = $signed({~sampleQ[0][SAMPLE_W-1], sampleQ[0][SAMPLE_W-2:0]});
    cosS    = $signed({~sampleQ[1][SAMPLE_W-1], sampleQ[1][SAMPLE_W-2:0]});
    gainSin = $signed({~iqWord[2*SAMPLE_W-1], iqWord[2*SAMPLE_W-2:SAMPLE_W]});
    gainCos = $signed({~iqWord[SAMPLE_W-1], iqWord[SAMPLE_W-2:0]});
    mixSum  = SUM_W'(sinS) * SUM_W'(gainSin) + SUM_W'(cosS) * SUM_W'(gainCos);
    mixTwos = SAMPLE_W'(mixSum >>> SAMPLE_W);
    mixCode = {~mixTwos[SAMPLE_W-1], mixTwos[SAMPLE_W-2:0]};
    nextDac = ctrl.amEnable ? mixCode : sampleQ[1];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      accQ       <= '0;
      sampleQ[0] <= '0;
      sampleQ[1] <= '0;
      dacQ       <= '0;
    end else begin
      if (ctrl.advance) begin
        accQ       <= accQ + (freqSel ? freqWord1 : freqWord0);
        sampleQ[0] <= lutOut[0];
        sampleQ[1] <= lutOut[1];
      end
      dacQ <= ctrl.blank ? '0 : nextDac;
    end
  end

  assign accValue  = accQ;
  assign cosSample = sampleQ[1];
  assign dacCode   = dacQ;
endmodule

// File: rtl/nco_qam_top.sv
module nco_qam_top
  import nco_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sleepPin,
  input  logic [CMD_W-1:0]      cmdWord,
  input  logic [ACC_W-1:0]      freqWord0,
  input  logic [ACC_W-1:0]      freqWord1,
  input  logic                  freqSel,
  input  logic [PHASE_W-1:0]    phaseOffset,
  input  logic [2*SAMPLE_W-1:0] iqWord,
  output logic [SAMPLE_W-1:0]   dacCode
);
  ctrl_t               ctrl;
  logic [ACC_W-1:0]    accValue;
  logic [SAMPLE_W-1:0] cosSample;

  nco_ctrl ctrl_i (
    .sleepPin (sleepPin),
    .cmdWord  (cmdWord),
    .ctrl     (ctrl)
  );

  nco_datapath #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .freqWord0   (freqWord0),
    .freqWord1   (freqWord1),
    .freqSel     (freqSel),
    .phaseOffset (phaseOffset),
    .iqWord      (iqWord),
    .accValue    (accValue),
    .cosSample   (cosSample),
    .dacCode     (dacCode)
  );
endmodule

// File: rtl/nco_qam_checker.sv
module nco_qam_checker #(
  parameter int ACC_W    = 32,
  parameter int SAMPLE_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                halt,
  input logic                amOn,
  input logic                freqSel,
  input logic [ACC_W-1:0]    freqWord0,
  input logic [ACC_W-1:0]    freqWord1,
  input logic [ACC_W-1:0]    accValue,
  input logic [SAMPLE_W-1:0] cosSample,
  input logic [SAMPLE_W-1:0] dacCode
);
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !halt |=> accValue == $past(accValue) + ($past(freqSel) ? $past(freqWord1) : $past(freqWord0))); // R2

  AST_COS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!halt && !amOn) |=> dacCode == $past(cosSample)); // R6

  AST_SLEEP_BLANK: assert property (@(posedge clk) disable iff (rst)
    halt |=> dacCode == '0); // R8

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(accValue)); // R9
endmodule

bind nco_qam_top nco_qam_checker #(.ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .halt      (ctrl.blank),
  .amOn      (ctrl.amEnable),
  .freqSel   (freqSel),
  .freqWord0 (freqWord0),
  .freqWord1 (freqWord1),
  .accValue  (accValue),
  .cosSample (cosSample),
  .dacCode   (dacCode)
);

// File: tb/nco_qam_top_tb_top.sv
`timescale 1ns/1ps
module nco_qam_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleepPin = 1'b0;
  logic [1:0]  cmdWord = '0;
  logic [31:0] freqWord0 = '0, freqWord1 = '0;
  logic        freqSel = 1'b0;
  logic [11:0] phaseOffset = '0;
  logic [19:0] iqWord = '0;
  logic [9:0]  dacCode;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nco_qam_top dut_i (
    .clk(clk), .rst(rst), .sleepPin(sleepPin), .cmdWord(cmdWord),
    .freqWord0(freqWord0), .freqWord1(freqWord1), .freqSel(freqSel),
    .phaseOffset(phaseOffset), .iqWord(iqWord), .dacCode(dacCode)
  );

  // Reference model built from the requirements.
  function automatic int refSine(input int a);
    int q, k, i, m;
    real ang;
    q = (a >> 10) & 3;
    k = a & 1023;
    i = (q & 1) ? 1023 - k : k;
    ang = 3.14159265358979 * real'(2 * i + 1) / 4096.0;
    m = $rtoi($floor(511.5 * $sin(ang) + 0.5));
    return (q & 2) ? 511 - m : 512 + m;
  endfunction

  function automatic int refMix(input int s, input int c, input int iq, input bit am);
    int sum;
    if (!am) return c;
    sum = (s - 512) * (((iq >> 10) & 1023) - 512) + (c - 512) * ((iq & 1023) - 512);
    return (sum >>> 10) + 512;
  endfunction

  logic [31:0] mAcc = '0;
  int mSin = 0, mCos = 0, mDac = 0;

  always @(posedge clk or posedge rst) begin
    int addr;
    if (rst) begin
      mAcc = '0; mSin = 0; mCos = 0; mDac = 0;
    end else if (sleepPin || cmdWord[1]) begin
      mDac = 0;
    end else begin
      mDac = refMix(mSin, mCos, int'(iqWord), cmdWord[0]);
      addr = (int'(mAcc[31:20]) + int'(phaseOffset)) & 4095;
      mSin = refSine(addr);
      mCos = refSine((addr + 1024) & 4095);
      mAcc = mAcc + (freqSel ? freqWord1 : freqWord0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic track(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(int'(dacCode) == mDac, tag, int'(dacCode), mDac);
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dacCode == 10'd0, "R1 during reset", int'(dacCode), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dacCode == 10'd0, "R1 first edge after reset", int'(dacCode), 0);
    @(negedge clk);
    check(dacCode == 10'd1023, "R5 cosine at zero phase", int'(dacCode), 1023);
    track(4, "R5 static zero phase");
  endtask

  task automatic testTone();
    freqWord0 = 32'h0010_0000;
    freqSel   = 1'b0;
    track(300, "R4 R6 one address per cycle");
    freqWord0 = 32'h0123_4567;
    track(200, "R2 odd tuning word");
  endtask

  task automatic testFsk();
    freqWord0 = 32'h0040_0000;
    freqWord1 = 32'hFF00_0000;
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      check(int'(dacCode) == mDac, "R2 per-cycle select", int'(dacCode), mDac);
      freqSel = (i % 3 == 0) || (i % 7 == 2);
    end
    freqSel = 1'b0;
  endtask

  task automatic testPhase();
    int offs [5] = '{0, 1024, 2048, 3071, 4095};
    freqWord0 = '0;
    foreach (offs[j]) begin
      phaseOffset = 12'(offs[j]);
      track(4, "R3 phase offset");
    end
    freqWord0 = 32'h0030_0000;
    phaseOffset = 12'd700;
    track(100, "R3 offset with sweep");
    phaseOffset = '0;
  endtask

  task automatic testAm();
    int gains [4] = '{20'hFFE00, 20'h80000, 20'h556AA, 20'h003FF};
    cmdWord = 2'b01;
    iqWord = {10'd512, 10'd512};
    repeat (3) @(negedge clk);
    check(dacCode == 10'd512, "R7 zero gains give midscale", int'(dacCode), 512);
    freqWord0 = 32'h0210_0000;
    foreach (gains[j]) begin
      iqWord = 20'(gains[j]);
      track(120, "R7 mixed I/Q");
    end
    cmdWord = 2'b00;
    track(20, "R6 mixing off again");
  endtask

  task automatic testSleep(input bit viaCmd, input bit am);
    string tag;
    tag = viaCmd ? "R9 command sleep" : "R8 pin sleep";
    cmdWord[0] = am;
    freqWord0 = 32'h0070_0000;
    track(10, tag);
    if (viaCmd) cmdWord[1] = 1'b1; else sleepPin = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check(dacCode == 10'd0, tag, int'(dacCode), 0);
    end
    if (viaCmd) cmdWord[1] = 1'b0; else sleepPin = 1'b0;
    track(60, tag);
    cmdWord = 2'b00;
  endtask

  initial begin
    iqWord = {10'd512, 10'd512};
    @(negedge clk);
    testReset();
    testTone();
    testFsk();
    testPhase();
    testAm();
    testSleep(1'b0, 1'b0);
    testSleep(1'b1, 1'b1);
    testSleep(1'b0, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule